// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off state of a square crosspoint matrix, eight rows by eight columns with the default parameters. One control bit belongs to each crosspoint. A caller picks one cell with a row select and a column select. It raises the strobe and presents the desired state on the data input. While the strobe is held high, the selected cell follows the data input. When the strobe drops, the cell keeps the last value it saw. A master reset turns every crosspoint off.

The block is clocked. It samples strobe, data and address on the system clock and reproduces the behaviour of a level-gated latch array. While the strobe is high, the update passes straight through. On the falling edge of the strobe, the final value is committed. The output is a flat vector of switch enables, with bit `col*ROWS + row` controlling the crosspoint between that row and that column. Reading it in groups of ROWS bits gives one column of the connectivity map per group. If the address moves while the strobe is held high, a protocol-error output is raised for one cycle.

Top module: `xpt_switch_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `sw_en` is 0 after that edge, whatever `strobe` and `data_in` are doing.
- R2: Bit index `col_sel*8 + row_sel` of `sw_en` (row in the low three bits, column in the high three bits) is the enable of crosspoint (row, column); 1 means on and 0 means off.
- R3: While `strobe` is held high, the selected bit of `sw_en` follows `data_in`, including repeated toggles.
- R4: After `strobe` falls, the selected bit keeps the last `data_in` value sampled while `strobe` was high; a change of `data_in` made together with or after the fall has no effect.
- R5: A write changes at most the one addressed bit; all other bits of `sw_en` keep their values.
- R6: Any set of crosspoints may be on at once, including several rows on one column and several columns on one row.
- R7: While `strobe` is low, changes on `data_in`, `row_sel` and `col_sel` leave `sw_en` unchanged.
- R8: `proto_err` is 1 for exactly the one cycle after a clock edge that samples a new `row_sel`/`col_sel` while `strobe` was high at both that edge and the previous one; it is 0 during a pulse whose address stays fixed.
- R9: After reset is released, `sw_en` stays all zero until the first strobe write.
- R10: An input applied before rising edge k shows on `sw_en` after rising edge k+1 and not after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master clear |
| strobe | input | 1 | Write strobe, active high |
| data_in | input | 1 | Desired crosspoint state |
| row_sel | input | ROW_W (3) | Row (X) select |
| col_sel | input | COL_W (3) | Column (Y) select |
| sw_en | output | 2**(ROW_W+COL_W) (64) | Crosspoint enables, bit col*ROWS+row |
| proto_err | output | 1 | Address changed during a strobe pulse |

## Verification
A wrong cell state shows up directly on `sw_en`, two clock edges after the stimulus that caused it. Because of this, the bench compares the whole 64-bit vector against a model after every write. That catches stray bits and wrongly mapped bits as well as missed writes. A fault in the falling-edge commit, or in write gating while the strobe is low, only shows when data moves around the strobe edge. Dedicated sequences therefore change data at the fall and while the strobe is idle, and check the bus a few cycles later.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int unsigned XPT_ROW_W = 3;
    localparam int unsigned XPT_COL_W = 3;

    // Phase of the write strobe, derived from two consecutive samples
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_HOLD  = 2'd2,
        PH_CLOSE = 2'd3
    } strobe_phase_e;

    function automatic strobe_phase_e phase_of(input logic cur, input logic prev);
        case ({cur, prev})
            2'b10:   return PH_OPEN;
            2'b11:   return PH_HOLD;
            2'b01:   return PH_CLOSE;
            default: return PH_IDLE;
        endcase
    endfunction

    // Phases in which the cell array accepts a write
    function automatic logic phase_writes(input strobe_phase_e ph);
        return (ph != PH_IDLE);
    endfunction

endpackage

// File: rtl/xpt_sampler.sv
module xpt_sampler #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          data_in,
    input  logic [AW-1:0] addr_in,
    output logic          stb_q,
    output logic          stb_p,
    output logic          data_q,
    output logic          data_p,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] addr_p
);

    // Two-deep sample history of the control inputs
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            stb_p  <= 1'b0;
            data_q <= 1'b0;
            data_p <= 1'b0;
            addr_q <= '0;
            addr_p <= '0;
        end else begin
            stb_q  <= strobe;
            stb_p  <= stb_q;
            data_q <= data_in;
            data_p <= data_q;
            addr_q <= addr_in;
            addr_p <= addr_q;
        end
    end

endmodule

// File: rtl/xpt_decoder.sv
module xpt_decoder #(
    parameter int unsigned AW = 6,
    localparam int unsigned N = 1 << AW
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);

    for (genvar i = 0; i < N; i++) begin : g_match
        assign sel[i] = en && (addr == AW'(i));
    end

endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sel,
    input  logic         wr_data,
    output logic [N-1:0] cells
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= 1'b0;
            end else if (sel[i]) begin
                cells[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/xpt_guard.sv
module xpt_guard #(
    parameter int unsigned AW = 6
) (
    input  logic          stb_q,
    input  logic          stb_p,
    input  logic [AW-1:0] addr_q,
    input  logic [AW-1:0] addr_p,
    output logic          proto_err
);

    // Address must not move between two high strobe samples
    always_comb begin
        proto_err = stb_q && stb_p && (addr_q != addr_p);
    end

endmodule

// File: rtl/xpt_switch_ctl.sv
module xpt_switch_ctl
    import xpt_pkg::*;
#(
    parameter int unsigned ROW_W = XPT_ROW_W,
    parameter int unsigned COL_W = XPT_COL_W,
    localparam int unsigned AW   = ROW_W + COL_W,
    localparam int unsigned N    = 1 << AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             data_in,
    input  logic [ROW_W-1:0] row_sel,
    input  logic [COL_W-1:0] col_sel,
    output logic [N-1:0]     sw_en,
    output logic             proto_err
);

    logic          stb_q, stb_p, data_q, data_p;
    logic [AW-1:0] addr_q, addr_p;
    logic [AW-1:0] wr_addr;
    logic          wr_data, wr_en;
    logic [N-1:0]  sel;
    strobe_phase_e phase;

    // Column in the high bits, row in the low bits: index col*ROWS + row
    xpt_sampler #(.AW(AW)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .data_in (data_in),
        .addr_in ({col_sel, row_sel}),
        .stb_q   (stb_q),
        .stb_p   (stb_p),
        .data_q  (data_q),
        .data_p  (data_p),
        .addr_q  (addr_q),
        .addr_p  (addr_p)
    );

    always_comb begin
        phase = phase_of(stb_q, stb_p);
        wr_en = phase_writes(phase);
        if (phase == PH_CLOSE) begin
            // Final commit uses the last sample taken while strobe was high
            wr_addr = addr_p;
            wr_data = data_p;
        end else begin
            wr_addr = addr_q;
            wr_data = data_q;
        end
    end

    xpt_decoder #(.AW(AW)) u_decoder (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (sel)
    );

    xpt_cell_array #(.N(N)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr_data (wr_data),
        .cells   (sw_en)
    );

    xpt_guard #(.AW(AW)) u_guard (
        .stb_q     (stb_q),
        .stb_p     (stb_p),
        .addr_q    (addr_q),
        .addr_p    (addr_p),
        .proto_err (proto_err)
    );

endmodule

// File: rtl/xpt_switch_chk.sv
module xpt_switch_chk #(
    parameter int unsigned AW = 6,
    localparam int unsigned N = 1 << AW
) (
    input logic          clk,
    input logic          rst,
    input logic          strobe,
    input logic [N-1:0]  sw_en,
    input logic          proto_err,
    input logic          stb_q,
    input logic          data_q,
    input logic [AW-1:0] addr_q
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sw_en == '0)); // R1

    AST_TRACK_DATA: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> (sw_en[$past(addr_q)] == $past(data_q))); // R3

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (rst)
        !stb_q |=> $stable(sw_en)); // R7

    AST_SINGLE_CELL: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> ($countones(sw_en ^ $past(sw_en)) <= 1)); // R5

    AST_ERR_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(strobe) && $past(strobe, 2))); // R8

endmodule

bind xpt_switch_ctl xpt_switch_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .sw_en     (sw_en),
    .proto_err (proto_err),
    .stb_q     (stb_q),
    .data_q    (data_q),
    .addr_q    (addr_q)
);

// File: tb/xpt_switch_ctl_bench.sv
module xpt_switch_ctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        data_in = 1'b0;
    logic [2:0]  row_sel = '0;
    logic [2:0]  col_sel = '0;
    logic [63:0] sw_en;
    logic        proto_err;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;
    logic [63:0] model = '0;

    always #2 clk = ~clk;

    xpt_switch_ctl u_xpt_switch_ctl (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .data_in   (data_in),
        .row_sel   (row_sel),
        .col_sel   (col_sel),
        .sw_en     (sw_en),
        .proto_err (proto_err)
    );

    // Vector format {col, row, data}
    localparam logic [6:0] VEC [0:11] = '{
        {3'd0, 3'd0, 1'b1}, {3'd7, 3'd7, 1'b1}, {3'd0, 3'd7, 1'b1},
        {3'd7, 3'd0, 1'b1}, {3'd3, 3'd2, 1'b1}, {3'd3, 3'd5, 1'b1},
        {3'd3, 3'd6, 1'b1}, {3'd1, 3'd2, 1'b1}, {3'd6, 3'd2, 1'b1},
        {3'd3, 3'd5, 1'b0}, {3'd0, 3'd0, 1'b0}, {3'd7, 3'd7, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] c, input logic [2:0] r, input logic d);
        @(negedge clk);
        col_sel = c; row_sel = r; data_in = d; strobe = 1'b1;
        wait_neg(2);
        strobe = 1'b0;
        wait_neg(2);
        model[{c, r}] = d;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        wait_neg(3);
        chk("R1 reset clears", sw_en, '0);
        chk("R8 no error in reset", 64'(proto_err), '0);
        rst = 1'b0;

        // R9 / R7: activity with strobe low after release
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            data_in = i[0]; row_sel = 3'(i); col_sel = 3'(7 - i);
        end
        wait_neg(2);
        chk("R9 zero until first write", sw_en, '0);
        chk("R7 strobe low ignored", sw_en, model);

        // R2 R5 R6: table walk
        for (int i = 0; i < 12; i++) begin
            do_write(VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
            chk("R5 R6 R2 table write", sw_en, model);
        end
        chk("R2 bit col*8+row", 64'(sw_en[3*8+2]), 64'(1));
        chk("R6 column 3 rows", 64'(sw_en[31:24]), 64'(8'b0100_0100));

        // R10 / R3 / R4: transparency and fall retention at (4,4)
        @(negedge clk);
        col_sel = 3'd4; row_sel = 3'd4; data_in = 1'b1; strobe = 1'b1;
        wait_neg(1);
        chk("R10 not after first edge", 64'(sw_en[36]), 64'(0));
        wait_neg(1);
        chk("R3 follows data high", 64'(sw_en[36]), 64'(1));
        chk("R8 no error with fixed address", 64'(proto_err), 64'(0));
        data_in = 1'b0;
        wait_neg(1);
        chk("R10 latency on toggle", 64'(sw_en[36]), 64'(1));
        wait_neg(1);
        chk("R3 follows data low", 64'(sw_en[36]), 64'(0));
        data_in = 1'b1;
        wait_neg(1);
        strobe = 1'b0; data_in = 1'b0;
        wait_neg(4);
        model[36] = 1'b1;
        chk("R4 value held after fall", sw_en, model);

        // R7: data and address move with strobe low
        @(negedge clk);
        col_sel = 3'd0; row_sel = 3'd1; data_in = 1'b1;
        wait_neg(2);
        data_in = 1'b0; col_sel = 3'd7;
        wait_neg(3);
        chk("R7 idle changes ignored", sw_en, model);

        // R8: address change during a pulse
        @(negedge clk);
        col_sel = 3'd1; row_sel = 3'd1; data_in = 1'b1; strobe = 1'b1;
        wait_neg(2);
        chk("R8 clean pulse", 64'(proto_err), 64'(0));
        row_sel = 3'd2;
        wait_neg(1);
        chk("R8 flag raised", 64'(proto_err), 64'(1));
        wait_neg(1);
        chk("R8 flag one cycle", 64'(proto_err), 64'(0));
        strobe = 1'b0;
        wait_neg(3);

        // R1: reset overrides strobe activity
        @(negedge clk);
        rst = 1'b1; col_sel = 3'd5; row_sel = 3'd5; data_in = 1'b1; strobe = 1'b1;
        wait_neg(3);
        chk("R1 reset beats strobe", sw_en, '0);
        strobe = 1'b0;
        wait_neg(1);
        rst = 1'b0;
        wait_neg(3);
        chk("R9 zero after second release", sw_en, '0);

        done = 1'b1;
        finish_run();
    end

endmodule